// File: doc/BRIEF.md
# Phase Slope Limiter with Lock Detect

This block sits in a telecom-rate digital PLL between the phase comparator and the loop filter. Once per 125 µs frame it accepts a signed phase-error sample and limits how far the error handed to the loop filter may move from the value it emitted for the previous frame. The recovered clock therefore cannot slew its phase faster than a fixed number of nanoseconds per frame. A fast-acquisition input bypasses this limit, so the loop can pull in quickly (within about half a second) before normal tracking takes over.

The block also produces a lock flag. Lock is earned only after a run of consecutive frames in which the output frequency matched the input and no limiting took place. It is lost at once when a frame is limited or the frequencies stop matching.

Top module: `phase_slew_limiter`

## Requirements
- R1: The error is a two's-complement value with 1 LSB = 1 ns. In normal mode (`fast_acq`=0) a sample whose difference from the previously emitted value lies within ±`SLOPE_LIM` (default 5) is emitted unchanged, and `clamp_active` is 0.
- R2: In normal mode a sample more than `SLOPE_LIM` above the previously emitted value is emitted as previous + `SLOPE_LIM`, with `clamp_active` = 1.
- R3: In normal mode a sample more than `SLOPE_LIM` below the previously emitted value is emitted as previous − `SLOPE_LIM`, with `clamp_active` = 1.
- R4: The reference for the slope is the last emitted (possibly limited) value, so a held large step is approached in `SLOPE_LIM` increments over successive frames.
- R5: With `fast_acq` = 1 the sample is emitted unchanged whatever its step size, `clamp_active` is 0, and the emitted value becomes the reference for the next frame.
- R6: `out_valid` is high exactly one clock after each cycle with `in_valid` high and low otherwise. `out_err` and `clamp_active` hold their values between frames.
- R7: `locked` rises together with `out_valid` for the `LOCK_FRAMES`-th (default 8) consecutive frame that is unlimited and has `freq_match` = 1, sampled in the same cycle as `in_valid`. Unlimited fast-mode frames count.
- R8: A limited frame drops `locked` in the same cycle as its `out_valid` and restarts the count of good frames.
- R9: A frame with `freq_match` = 0 drops `locked` and restarts the count of good frames.
- R10: Reset sets the reference value and `out_err` to 0 and deasserts `out_valid`, `clamp_active` and `locked`. The reset is applied asynchronously and released after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_valid | input | 1 | One-cycle strobe marking a new frame sample |
| in_err | input | ERR_W | Signed phase error, 1 LSB = 1 ns |
| fast_acq | input | 1 | 1 = fast acquisition, limit bypassed |
| freq_match | input | 1 | Output frequency equals input frequency |
| out_valid | output | 1 | Strobe for the limited sample |
| out_err | output | ERR_W | Limited phase error towards the loop filter |
| clamp_active | output | 1 | Last frame was limited |
| locked | output | 1 | Lock indication |

## Verification
Every result (`out_err`, `clamp_active`, `locked`, `out_valid`) registers on the clock edge that samples `in_valid`, so each is due one cycle after the stimulus. The bench drives a frame on a falling edge, lets one rising edge pass, and reads the outputs on the following falling edge. On that same idle cycle it confirms that `out_valid` has fallen while the data holds. After reset is released, the bench waits out the two-edge release delay before it sends the first frame.

// File: rtl/psl_pkg.sv
package psl_pkg;
  typedef struct packed {
    logic clamped;
    logic pos_side;
  } clamp_flags_t;
endpackage

// File: rtl/psl_clamp.sv
module psl_clamp #(
  parameter int ERR_W     = 16,
  parameter int SLOPE_LIM = 5
) (
  input  logic signed [ERR_W-1:0] sample_i,
  input  logic signed [ERR_W-1:0] ref_i,
  input  logic                    bypass_i,
  output logic signed [ERR_W-1:0] err_o,
  output psl_pkg::clamp_flags_t   flags_o
);
  localparam int XW = ERR_W + 1;
  localparam logic signed [XW-1:0] LIM_X = XW'(SLOPE_LIM);

  logic signed [XW-1:0] sample_x, ref_x, step_x, up_x, dn_x;
  logic over_hi, over_lo;

  always_comb begin
    sample_x = {sample_i[ERR_W-1], sample_i};
    ref_x    = {ref_i[ERR_W-1], ref_i};
    step_x   = sample_x - ref_x;
    up_x     = ref_x + LIM_X;
    dn_x     = ref_x - LIM_X;
    over_hi  = !bypass_i && (step_x > LIM_X);
    over_lo  = !bypass_i && (step_x < -LIM_X);
  end

  always_comb begin
    err_o            = sample_i;
    flags_o.clamped  = 1'b0;
    flags_o.pos_side = 1'b0;
    if (over_hi) begin
      err_o            = up_x[ERR_W-1:0];
      flags_o.clamped  = 1'b1;
      flags_o.pos_side = 1'b1;
    end else if (over_lo) begin
      err_o            = dn_x[ERR_W-1:0];
      flags_o.clamped  = 1'b1;
    end
  end

  logic signed [XW-1:0] emitted_step;
  assign emitted_step = {err_o[ERR_W-1], err_o} - ref_x;

  // R2 R3
  always_comb begin
    if (!bypass_i) begin
      slope_bound_chk: assert (emitted_step <= LIM_X && emitted_step >= -LIM_X);
    end
  end
endmodule

// File: rtl/psl_lock.sv
module psl_lock #(
  parameter int LOCK_FRAMES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_i,
  input  logic clamped_i,
  input  logic freq_ok_i,
  output logic locked_o
);
  localparam int CW = $clog2(LOCK_FRAMES + 1);
  localparam logic [CW-1:0] FULL = CW'(LOCK_FRAMES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lock_q, lock_d;

  always_comb begin
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (frame_i) begin
      if (clamped_i || !freq_ok_i) begin
        cnt_d  = '0;
        lock_d = 1'b0;
      end else begin
        if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
        lock_d = (cnt_d == FULL);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (frame_i) begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign locked_o = lock_q;

  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(cnt_q) == FULL - 1'b1);

  // R9
  freq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i && !freq_ok_i |=> !lock_q && cnt_q == '0);
endmodule

// File: rtl/phase_slew_limiter.sv
module phase_slew_limiter #(
  parameter int ERR_W       = 16,
  parameter int SLOPE_LIM   = 5,
  parameter int LOCK_FRAMES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ERR_W-1:0] in_err,
  input  logic             fast_acq,
  input  logic             freq_match,
  output logic             out_valid,
  output logic [ERR_W-1:0] out_err,
  output logic             clamp_active,
  output logic             locked
);
  import psl_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic signed [ERR_W-1:0] ref_q, ref_d, lim_err;
  clamp_flags_t            flags;
  logic                    vld_q, clamp_q, clamp_d;

  psl_clamp #(.ERR_W(ERR_W), .SLOPE_LIM(SLOPE_LIM)) u_clamp (
    .sample_i (in_err),
    .ref_i    (ref_q),
    .bypass_i (fast_acq),
    .err_o    (lim_err),
    .flags_o  (flags)
  );

  always_comb begin
    ref_d   = ref_q;
    clamp_d = clamp_q;
    if (in_valid) begin
      ref_d   = lim_err;
      clamp_d = flags.clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ref_q   <= '0;
      clamp_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        ref_q   <= ref_d;
        clamp_q <= clamp_d;
      end
    end
  end

  psl_lock #(.LOCK_FRAMES(LOCK_FRAMES)) u_lock (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .frame_i   (in_valid),
    .clamped_i (flags.clamped),
    .freq_ok_i (freq_match),
    .locked_o  (locked)
  );

  assign out_valid    = vld_q;
  assign out_err      = ref_q;
  assign clamp_active = clamp_q;

  // R6
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);

  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid && $stable(out_err) && $stable(clamp_active));

  // R5
  fast_pass_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid && fast_acq |=> !clamp_active && out_err == $past(in_err));

  // R8
  clamp_unlock_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid && clamp_active |-> !locked);
endmodule

// File: tb/phase_slew_limiter_tb.sv
`timescale 1ns/1ps
module phase_slew_limiter_tb;
  localparam int ERR_W = 16;
  localparam int LIM   = 5;
  localparam int NLOCK = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [ERR_W-1:0] in_err = '0;
  logic fast_acq = 1'b0;
  logic freq_match = 1'b0;
  logic out_valid;
  logic [ERR_W-1:0] out_err;
  logic clamp_active;
  logic locked;

  int checks = 0;
  int failures = 0;
  int ref_val = 0;
  int good_run = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  phase_slew_limiter #(.ERR_W(ERR_W), .SLOPE_LIM(LIM), .LOCK_FRAMES(NLOCK)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_err(in_err),
    .fast_acq(fast_acq), .freq_match(freq_match), .out_valid(out_valid),
    .out_err(out_err), .clamp_active(clamp_active), .locked(locked)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ref_val = 0;
    good_run = 0;
  endtask

  // Sends one frame, predicts from the requirements, checks outputs one cycle later
  task automatic frame(input string req, input int err, input bit fast, input bit fm);
    int step, exp_err;
    bit exp_clamp, exp_lock;
    step = err - ref_val;
    exp_err = err;
    exp_clamp = 1'b0;
    if (!fast && step > LIM) begin exp_err = ref_val + LIM; exp_clamp = 1'b1; end
    else if (!fast && step < -LIM) begin exp_err = ref_val - LIM; exp_clamp = 1'b1; end
    if (exp_clamp || !fm) good_run = 0;
    else good_run++;
    exp_lock = (good_run >= NLOCK);
    ref_val = exp_err;
    @(negedge clk);
    in_valid = 1'b1;
    in_err = ERR_W'(err);
    fast_acq = fast;
    freq_match = fm;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " out_valid"}, int'(out_valid), 1);
    check({req, " out_err"}, int'($signed(out_err)), exp_err);
    check({req, " clamp_active"}, int'(clamp_active), int'(exp_clamp));
    check({req, " locked"}, int'(locked), int'(exp_lock));
    @(negedge clk);
    check({req, " idle out_valid"}, int'(out_valid), 0);
    check({req, " idle hold"}, int'($signed(out_err)), exp_err);
  endtask

  task automatic t_reset_state();
    check("R10 out_valid", int'(out_valid), 0);
    check("R10 out_err", int'($signed(out_err)), 0);
    check("R10 clamp_active", int'(clamp_active), 0);
    check("R10 locked", int'(locked), 0);
  endtask

  task automatic t_pass_small();
    frame("R1 step+3", 3, 1'b0, 1'b0);
    frame("R1 step-4", -1, 1'b0, 1'b0);
    frame("R1 step+5 edge", 4, 1'b0, 1'b0);
  endtask

  task automatic t_clamp();
    frame("R2 up clamp", 100, 1'b0, 1'b1);
    frame("R4 walk", 100, 1'b0, 1'b1);
    frame("R4 walk2", 100, 1'b0, 1'b1);
    frame("R3 down clamp", -50, 1'b0, 1'b1);
    frame("R3 step-6", ref_val - 6, 1'b0, 1'b1);
  endtask

  task automatic t_fast();
    frame("R5 fast jump", 1000, 1'b1, 1'b0);
    frame("R5 fast neg", -2000, 1'b1, 1'b0);
    frame("R5 ref follows", -1997, 1'b0, 1'b0);
  endtask

  task automatic t_lock();
    for (int i = 0; i < NLOCK + 1; i++) frame("R7 qualify", ref_val + (i % 3) - 1, 1'b0, 1'b1);
    frame("R9 freq lost", ref_val, 1'b0, 1'b0);
    for (int i = 0; i < NLOCK; i++) frame("R7 requalify", ref_val + 2, i == 3, 1'b1);
    frame("R8 clamp unlock", ref_val + 40, 1'b0, 1'b1);
    frame("R8 recount", ref_val, 1'b0, 1'b1);
  endtask

  task automatic t_reset_mid();
    do_reset();
    t_reset_state();
    frame("R10 ref cleared", 10, 1'b0, 1'b1);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_pass_small();
    t_clamp();
    t_fast();
    t_lock();
    t_reset_mid();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule